// File: doc/BRIEF.md
# LSB-First Serial Magnitude Comparator

This block decides the order of two unsigned numbers that are shifted in one bit pair per clock, least significant pair first. Each cycle it takes one bit of the first operand on `a_i` and the matching bit of the second operand on `b_i`. The registered flags `gt_o` and `lt_o` show how the two numbers compare when only the pairs received so far are counted. The block has no fixed operand length. The user pulses `start_i` together with the first pair of a new comparison and reads the flags once the last, most significant pair has been clocked in.

Bits arrive from the bottom up, so every pair is more significant than all the pairs before it. A pair whose bits differ therefore sets the result, whatever was decided before. A pair whose bits match leaves the result as it was. The relation is held in a three-valued state: equal, greater or less. The parameter `STATE_STYLE` chooses how that state is stored, either as a two-bit binary code or as three one-hot flops. The flags behave the same way in both styles.

Top module: `serial_mag_cmp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `gt_o` and `lt_o` are both 0, which means equal. Reset is asynchronous and active-low.
- R2: A clock edge that samples `a_i`=1 and `b_i`=0 makes the flags `gt_o`=1, `lt_o`=0 after that edge. This holds whatever the earlier state was and whatever the value of `start_i`.
- R3: A clock edge that samples `a_i`=0 and `b_i`=1 makes the flags `gt_o`=0, `lt_o`=1 after that edge. This holds whatever the earlier state was and whatever the value of `start_i`.
- R4: A clock edge that samples `a_i`=`b_i` with `start_i`=0 leaves both flags unchanged.
- R5: A clock edge that samples `start_i`=1 drops the previous result and still evaluates the pair sampled at the same edge. If that pair's bits match, both flags are 0 after the edge. If they differ, R2 or R3 applies.
- R6: `gt_o` and `lt_o` are never 1 at the same time.
- R7: After a start and N pairs (any N ≥ 1), the flags give the unsigned comparison of the two N-bit operands: (1,0) for first greater, (0,1) for first smaller, (0,0) for equal.
- R8: Both values of `STATE_STYLE` (0 for a binary code, 1 for one-hot) give the same flag behaviour. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the equal state |
| start_i | input | 1 | Begins a new comparison with the pair on this cycle |
| a_i | input | 1 | Current bit of the first operand, LSB first |
| b_i | input | 1 | Current bit of the second operand, LSB first |
| gt_o | output | 1 | Registered flag: first operand greater so far |
| lt_o | output | 1 | Registered flag: first operand smaller so far |

## Verification
The assertions check the per-edge rules on every cycle. After a differing pair the flags must take the matching value. A matching pair without start must leave the flags as they were. A matching pair with start must clear them. The two flags must never be high together, and in the one-hot style exactly one state flop is set. Only the bench scenarios can show that a whole operand of any width gives the right final result. They also show that a later differing pair overrides an earlier one, that reset clears a decided result at once, and that back-to-back comparisons do not leak state into one another.

// File: rtl/serial_mag_cmp_pkg.sv
package serial_mag_cmp_pkg;

   // Relation between the two operands over the bits seen so far.
   // The bit positions matter: bit 0 drives the greater flag and bit 1
   // drives the less flag in the binary storage style.
   typedef enum logic [1:0] {
      REL_EQ = 2'b00,
      REL_GT = 2'b01,
      REL_LT = 2'b10
   } rel_t;

   localparam int STYLE_BINARY = 0;
   localparam int STYLE_ONEHOT = 1;

endpackage

// File: rtl/serial_mag_cmp_decide.sv
module serial_mag_cmp_decide
   import serial_mag_cmp_pkg::*;
(
   input  logic start_i,
   input  logic a_i,
   input  logic b_i,
   input  rel_t cur_rel_i,
   output rel_t nxt_rel_o
);

   logic diff;
   rel_t pair_rel;
   rel_t base_rel;

   // A differing pair is more significant than all earlier pairs.
   assign diff     = a_i ^ b_i;
   assign pair_rel = a_i ? REL_GT : REL_LT;
   // A start discards the earlier history before this pair is applied.
   assign base_rel = start_i ? REL_EQ : cur_rel_i;

   always_comb begin
      if (diff) nxt_rel_o = pair_rel;
      else      nxt_rel_o = base_rel;
   end

endmodule

// File: rtl/serial_mag_cmp_state.sv
module serial_mag_cmp_state
   import serial_mag_cmp_pkg::*;
#(
   parameter int STATE_STYLE = STYLE_BINARY
) (
   input  logic clk,
   input  logic rst_n,
   input  rel_t nxt_rel_i,
   output rel_t cur_rel_o,
   output logic gt_o,
   output logic lt_o
);

   generate
      if (STATE_STYLE == STYLE_BINARY) begin : g_binary
         logic [1:0] code_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_q <= REL_EQ;
            else        code_q <= nxt_rel_i;
         end

         assign cur_rel_o = rel_t'(code_q);
         assign gt_o      = code_q[0];
         assign lt_o      = code_q[1];

         // R6: the unused code 2'b11 is never reached
         p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            code_q != 2'b11);
      end else if (STATE_STYLE == STYLE_ONEHOT) begin : g_onehot
         logic eq_q;
         logic gt_q;
         logic lt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               eq_q <= 1'b1;
               gt_q <= 1'b0;
               lt_q <= 1'b0;
            end else begin
               eq_q <= (nxt_rel_i == REL_EQ);
               gt_q <= (nxt_rel_i == REL_GT);
               lt_q <= (nxt_rel_i == REL_LT);
            end
         end

         always_comb begin
            if (gt_q)      cur_rel_o = REL_GT;
            else if (lt_q) cur_rel_o = REL_LT;
            else           cur_rel_o = REL_EQ;
         end
         assign gt_o = gt_q;
         assign lt_o = lt_q;

         // R6: exactly one state flop set
         p_onehot_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({eq_q, gt_q, lt_q}) == 1);
      end else begin : g_bad_style
         $error("serial_mag_cmp_state: STATE_STYLE must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
   import serial_mag_cmp_pkg::*;
#(
   parameter int STATE_STYLE = STYLE_BINARY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic a_i,
   input  logic b_i,
   output logic gt_o,
   output logic lt_o
);

   // R8: only the two known storage styles elaborate
   if (STATE_STYLE != STYLE_BINARY && STATE_STYLE != STYLE_ONEHOT) begin : g_chk_style_r8
      $error("serial_mag_cmp: unsupported STATE_STYLE");
   end

   rel_t cur_rel;
   rel_t nxt_rel;

   serial_mag_cmp_decide u_decide (
      .start_i   (start_i),
      .a_i       (a_i),
      .b_i       (b_i),
      .cur_rel_i (cur_rel),
      .nxt_rel_o (nxt_rel)
   );

   serial_mag_cmp_state #(
      .STATE_STYLE (STATE_STYLE)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_rel_i (nxt_rel),
      .cur_rel_o (cur_rel),
      .gt_o      (gt_o),
      .lt_o      (lt_o)
   );

   p_gt_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_i && !b_i) |=> (gt_o && !lt_o));

   p_lt_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_i && b_i) |=> (!gt_o && lt_o));

   p_hold_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && (a_i == b_i)) |=> ($stable(gt_o) && $stable(lt_o)));

   p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (a_i == b_i)) |=> (!gt_o && !lt_o));

   p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(gt_o && lt_o));

endmodule

// File: tb/serial_mag_cmp_test.sv
module serial_mag_cmp_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic a_i = 1'b0;
   logic b_i = 1'b0;
   logic gt_bin, lt_bin, gt_oh, lt_oh;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_mag_cmp #(.STATE_STYLE(0)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
      .gt_o(gt_bin), .lt_o(lt_bin)
   );

   serial_mag_cmp #(.STATE_STYLE(1)) uut_oh (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
      .gt_o(gt_oh), .lt_o(lt_oh)
   );

   task automatic check(input string req, input logic eg, input logic el);
      checks++;
      if (gt_bin !== eg || lt_bin !== el) begin
         errors++;
         $display("FAIL %s binary: gt/lt=%b%b expected %b%b", req, gt_bin, lt_bin, eg, el);
      end
      // R8: one-hot style must match the same expectation
      checks++;
      if (gt_oh !== eg || lt_oh !== el) begin
         errors++;
         $display("FAIL R8/%s onehot: gt/lt=%b%b expected %b%b", req, gt_oh, lt_oh, eg, el);
      end
   endtask

   // Drive one pair at the falling edge, then sample just after the rising edge.
   task automatic step(input logic st, input logic a, input logic b);
      @(negedge clk);
      start_i = st; a_i = a; b_i = b;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #1;
      check("R1", 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", 1'b0, 1'b0);
   endtask

   task automatic t_single_pairs();
      step(1'b1, 1'b1, 1'b0); check("R2", 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1); check("R3", 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b0); check("R2", 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b1); check("R3", 1'b0, 1'b1);
   endtask

   task automatic t_hold();
      step(1'b1, 1'b1, 1'b0); check("R2", 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0); check("R4", 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1); check("R4", 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1); check("R3", 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b1); check("R4", 1'b0, 1'b1);
   endtask

   task automatic t_start();
      step(1'b0, 1'b0, 1'b1); check("R3", 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1); check("R5", 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0); check("R2", 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b0); check("R5", 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1); check("R5", 1'b0, 1'b1);
   endtask

   task automatic t_reset_mid();
      step(1'b0, 1'b1, 1'b0); check("R2", 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      a_i = 1'b0; b_i = 1'b0; start_i = 1'b0;
      @(posedge clk); #1;
      check("R1", 1'b0, 1'b0);
   endtask

   // Shift two words LSB first and compare the final flags with an unsigned compare.
   task automatic t_word(input logic [31:0] av, input logic [31:0] bv, input int n);
      logic eg, el;
      logic [31:0] am, bm;
      am = (n == 32) ? av : (av & ((32'd1 << n) - 1));
      bm = (n == 32) ? bv : (bv & ((32'd1 << n) - 1));
      eg = (am > bm);
      el = (am < bm);
      for (int i = 0; i < n; i++) begin
         step((i == 0), av[i], bv[i]);
      end
      check("R7", eg, el);
   endtask

   initial begin
      t_reset();
      t_single_pairs();
      t_hold();
      t_start();
      t_reset_mid();
      // R7: lower pair decided first, then overridden by a higher pair
      t_word(32'h0000_0001, 32'h0000_0002, 2);
      t_word(32'h0000_0005, 32'h0000_0005, 3);
      t_word(32'h0000_0080, 32'h0000_007F, 8);
      t_word(32'h0000_7FFE, 32'h0000_8001, 16);
      t_word(32'hFFFF_FFFF, 32'hFFFF_FFFE, 32);
      t_word(32'h0000_0000, 32'h0000_0001, 1);
      t_word(32'h1234_5678, 32'h1234_5679, 32);
      t_word(32'hA5A5_0000, 32'h5A5A_FFFF, 32);
      t_word(32'h0000_0003, 32'h0000_0003, 5);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule